// File: doc/BRIEF.md
# Link State and Mode Selector

This block sits beside the control registers of a 10/100 twisted-pair PHY and decides two things every cycle: which link state the port is in, and which speed and duplex the transmit and receive paths should run at. Speed and duplex can come from three places. There is a speed/duplex pair in the MAC-side control register, a pair in the PHY-side control register, and a result delivered by the negotiation exchange. The exchange itself is outside this block and is represented by a completion strobe carrying a speed/duplex result. Two enables, one in each register, plus a link-disable bit choose the source in a fixed priority order.

When negotiation is active and a negotiated link drops, the port goes silent. Transmit is inhibited, link pulses included, for a hold-off window that the parameters bound between a minimum and a maximum tick count (1200 to 1500 ms in a real system). After the hold-off the block returns to the negotiating link-fail state. Software can force a renegotiation at any time with a restart strobe, which models a self-clearing register bit. A status bit acknowledges that negotiation has completed. The idle-pattern select tells the line driver to send normal link pulses at 10 Mbps or the TX idle pattern at 100 Mbps.

The state machine has five states. FRC_FAIL and FRC_PASS are the forced modes, link down and link up. AN_FAIL means negotiating with the link down. AN_PASS means negotiated with the link up. AN_HOLD is the silent hold-off. The transitions are checked in this priority:
- Negotiation inactive: go to FRC_PASS when the link is good or link-disable is set, otherwise go to FRC_FAIL.
- Restart strobe: go to AN_FAIL.
- FRC_FAIL or FRC_PASS with negotiation now active: go to AN_FAIL.
- AN_FAIL: go to AN_PASS on a completion strobe with the link good.
- AN_PASS: go to AN_HOLD on loss of link.
- AN_HOLD: go to AN_FAIL when the hold-off timer expires.

Top module: `link_mode_ctrl`

## Requirements
- R1: With link-disable clear and the MAC-side enable clear, the block is in a forced state. While the link is down (FRC_FAIL), `spd100`/`fdx` equal the MAC-side bits one clock after they are applied. `link_pass` follows `link_good` one clock later.
- R2: With link-disable clear, the MAC-side enable set and the PHY-side enable clear, the block is in a forced state. While the link is down, `spd100`/`fdx` equal the PHY-side bits one clock later.
- R3: Link-disable overrides both enables. One clock after it is set, `link_pass` is 1 whatever `link_good` is, and `spd100`/`fdx` come from the PHY-side bits.
- R4: With both enables set and link-disable clear, the block negotiates (AN_FAIL, `link_pass`=0, `tx_inhibit`=0). A completion strobe with `link_good`=1 moves it to AN_PASS one clock later. It then sets `neg_ack`, sets `link_pass`, and loads the strobe's speed/duplex. A strobe with `link_good`=0 leaves it negotiating. After the strobe, later changes on the result inputs have no effect.
- R5: Loss of link in AN_PASS raises `tx_inhibit` and drops `link_pass` one clock later. `tx_inhibit` stays high for exactly (HOLD_MIN_TICKS+HOLD_MAX_TICKS)/2 cycles, which lies inside [HOLD_MIN_TICKS, HOLD_MAX_TICKS]. `neg_ack` stays set during the hold-off. The block then returns to AN_FAIL with `tx_inhibit`=0 and `neg_ack`=0.
- R6: While negotiation is active, a restart strobe moves the block to AN_FAIL one clock later from any state, the hold-off included. This clears `neg_ack`, `link_pass` and `tx_inhibit`. In a forced state the strobe has no effect.
- R7: `idle_txidle` is 1 (TX idle pattern) when the resolved speed is 100 Mbps, and 0 (normal link pulses) at 10 Mbps. This includes the link-disabled case.
- R8: The resolved `spd100`/`fdx` are registered. They load only on a state change or while in FRC_FAIL. A change of the source bits while in FRC_PASS does not reach the outputs until the state changes.
- R9: After reset all outputs are 0 and the block is in FRC_FAIL.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mac_an_en | input | 1 | MAC-side negotiation enable |
| mac_spd100 | input | 1 | MAC-side speed bit (1 = 100 Mbps) |
| mac_fdx | input | 1 | MAC-side duplex bit (1 = full) |
| phy_an_en | input | 1 | PHY-side negotiation enable |
| phy_spd100 | input | 1 | PHY-side speed bit (1 = 100 Mbps) |
| phy_fdx | input | 1 | PHY-side duplex bit (1 = full) |
| an_restart | input | 1 | One-cycle restart strobe (self-clearing bit) |
| link_dis | input | 1 | Link integrity disable |
| link_good | input | 1 | Link-good indication from the receive side |
| neg_done | input | 1 | Negotiation completion strobe |
| neg_spd100 | input | 1 | Negotiated speed, valid with neg_done |
| neg_fdx | input | 1 | Negotiated duplex, valid with neg_done |
| spd100 | output | 1 | Resolved speed (1 = 100 Mbps) |
| fdx | output | 1 | Resolved duplex (1 = full) |
| link_pass | output | 1 | 1 = link-pass state, 0 = link-fail state |
| tx_inhibit | output | 1 | All transmission suppressed (hold-off) |
| idle_txidle | output | 1 | 1 = send TX idle, 0 = send link pulses |
| neg_ack | output | 1 | Negotiation-complete status |

## Verification
Some properties are checked on every cycle. The hold-off window always lies inside its tick bounds. `tx_inhibit` and `link_pass` are never high together. Link-disable always forces a pass. A restart always clears the link and acknowledge outputs. `neg_ack` only rises after a completion strobe. In forced link-down states the outputs always track the chosen register bits. Other behaviours only the directed scenarios can show. These are the exact hold-off length, the holding of new register bits while in FRC_PASS, the restart cutting the hold-off short, the strobe being ignored without link, and the idle-pattern choice.

// File: rtl/lmc_pkg.sv
package lmc_pkg;

    typedef enum logic [2:0] {
        LS_FRC_FAIL = 3'd0,
        LS_FRC_PASS = 3'd1,
        LS_AN_FAIL  = 3'd2,
        LS_AN_PASS  = 3'd3,
        LS_AN_HOLD  = 3'd4
    } lmc_state_e;

    typedef struct packed {
        logic spd100;
        logic fdx;
    } lmc_mode_t;

endpackage

// File: rtl/lmc_resolve.sv
module lmc_resolve
    import lmc_pkg::*;
(
    input  logic      link_dis,
    input  logic      mac_an_en,
    input  logic      phy_an_en,
    input  lmc_mode_t mac_mode,
    input  lmc_mode_t phy_mode,
    input  lmc_mode_t neg_mode,
    output lmc_mode_t sel_mode,
    output logic      an_active
);

    // Priority: link disable, then MAC enable, then PHY enable, then result.
    always_comb begin
        an_active = 1'b0;
        if (link_dis) begin
            sel_mode = phy_mode;
        end else if (!mac_an_en) begin
            sel_mode = mac_mode;
        end else if (!phy_an_en) begin
            sel_mode = phy_mode;
        end else begin
            sel_mode  = neg_mode;
            an_active = 1'b1;
        end
    end

endmodule

// File: rtl/lmc_holdoff.sv
module lmc_holdoff #(
    parameter int HOLD_LEN = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic expire
);

    localparam int CW = $clog2(HOLD_LEN + 1);
    localparam logic [CW-1:0] LAST = CW'(HOLD_LEN - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt <= '0;
        end else if (cnt != LAST) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign expire = run && (cnt == LAST);

endmodule

// File: rtl/lmc_mode_reg.sv
module lmc_mode_reg
    import lmc_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      load,
    input  lmc_mode_t sel_mode,
    input  logic      neg_done,
    input  lmc_mode_t neg_live,
    output lmc_mode_t neg_pick,
    output lmc_mode_t cur_mode
);

    lmc_mode_t neg_keep;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            neg_keep <= '0;
        end else if (neg_done) begin
            neg_keep <= neg_live;
        end
    end

    assign neg_pick = neg_done ? neg_live : neg_keep;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_mode <= '0;
        end else if (load) begin
            cur_mode <= sel_mode;
        end
    end

endmodule

// File: rtl/lmc_fsm.sv
module lmc_fsm
    import lmc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       an_active,
    input  logic       link_dis,
    input  logic       link_good,
    input  logic       restart,
    input  logic       neg_done,
    input  logic       hold_expire,
    output logic       mode_load,
    output logic       hold_run,
    output logic       link_pass,
    output logic       tx_inhibit,
    output logic       neg_ack
);

    lmc_state_e state, state_nx;

    always_comb begin
        state_nx = state;
        if (!an_active) begin
            state_nx = (link_good || link_dis) ? LS_FRC_PASS : LS_FRC_FAIL;
        end else if (restart) begin
            state_nx = LS_AN_FAIL;
        end else begin
            unique case (state)
                LS_FRC_FAIL, LS_FRC_PASS: state_nx = LS_AN_FAIL;
                LS_AN_FAIL: state_nx = (neg_done && link_good) ? LS_AN_PASS : LS_AN_FAIL;
                LS_AN_PASS: state_nx = link_good ? LS_AN_PASS : LS_AN_HOLD;
                LS_AN_HOLD: state_nx = hold_expire ? LS_AN_FAIL : LS_AN_HOLD;
                default:    state_nx = LS_FRC_FAIL;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= LS_FRC_FAIL;
        end else begin
            state <= state_nx;
        end
    end

    // Acknowledge survives the hold-off, cleared on any return to negotiation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            neg_ack <= 1'b0;
        end else if (state_nx == LS_AN_PASS && state == LS_AN_FAIL) begin
            neg_ack <= 1'b1;
        end else if (state_nx != LS_AN_PASS && state_nx != LS_AN_HOLD) begin
            neg_ack <= 1'b0;
        end
    end

    always_comb begin
        link_pass  = 1'b0;
        tx_inhibit = 1'b0;
        hold_run   = 1'b0;
        unique case (state)
            LS_FRC_PASS, LS_AN_PASS: link_pass = 1'b1;
            LS_AN_HOLD: begin
                tx_inhibit = 1'b1;
                hold_run   = 1'b1;
            end
            default: ;
        endcase
        mode_load = (state_nx != state) || (state == LS_FRC_FAIL);
    end

endmodule

// File: rtl/link_mode_ctrl.sv
module link_mode_ctrl
    import lmc_pkg::*;
#(
    parameter int HOLD_MIN_TICKS = 30_000_000,
    parameter int HOLD_MAX_TICKS = 37_500_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic mac_an_en,
    input  logic mac_spd100,
    input  logic mac_fdx,
    input  logic phy_an_en,
    input  logic phy_spd100,
    input  logic phy_fdx,
    input  logic an_restart,
    input  logic link_dis,
    input  logic link_good,
    input  logic neg_done,
    input  logic neg_spd100,
    input  logic neg_fdx,
    output logic spd100,
    output logic fdx,
    output logic link_pass,
    output logic tx_inhibit,
    output logic idle_txidle,
    output logic neg_ack
);

    localparam int HOLD_LEN = (HOLD_MIN_TICKS + HOLD_MAX_TICKS) / 2;

    lmc_mode_t sel_mode, neg_pick, cur_mode;
    logic      an_active, mode_load, hold_run, hold_expire;

    lmc_resolve u_resolve (
        .link_dis  (link_dis),
        .mac_an_en (mac_an_en),
        .phy_an_en (phy_an_en),
        .mac_mode  ('{spd100: mac_spd100, fdx: mac_fdx}),
        .phy_mode  ('{spd100: phy_spd100, fdx: phy_fdx}),
        .neg_mode  (neg_pick),
        .sel_mode  (sel_mode),
        .an_active (an_active)
    );

    lmc_holdoff #(.HOLD_LEN(HOLD_LEN)) u_holdoff (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (hold_run),
        .expire (hold_expire)
    );

    lmc_mode_reg u_mode (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (mode_load),
        .sel_mode (sel_mode),
        .neg_done (neg_done),
        .neg_live ('{spd100: neg_spd100, fdx: neg_fdx}),
        .neg_pick (neg_pick),
        .cur_mode (cur_mode)
    );

    lmc_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .an_active   (an_active),
        .link_dis    (link_dis),
        .link_good   (link_good),
        .restart     (an_restart),
        .neg_done    (neg_done),
        .hold_expire (hold_expire),
        .mode_load   (mode_load),
        .hold_run    (hold_run),
        .link_pass   (link_pass),
        .tx_inhibit  (tx_inhibit),
        .neg_ack     (neg_ack)
    );

    assign spd100      = cur_mode.spd100;
    assign fdx         = cur_mode.fdx;
    assign idle_txidle = cur_mode.spd100;

endmodule

// File: rtl/link_mode_ctrl_chk.sv
module link_mode_ctrl_chk #(
    parameter int HOLD_MIN_TICKS = 30_000_000,
    parameter int HOLD_MAX_TICKS = 37_500_000
) (
    input logic clk,
    input logic rst_n,
    input logic mac_an_en,
    input logic mac_spd100,
    input logic mac_fdx,
    input logic phy_an_en,
    input logic phy_spd100,
    input logic phy_fdx,
    input logic an_restart,
    input logic link_dis,
    input logic neg_done,
    input logic spd100,
    input logic fdx,
    input logic link_pass,
    input logic tx_inhibit,
    input logic neg_ack
);

    localparam int HW = $clog2(HOLD_MAX_TICKS + 2);
    localparam logic [HW-1:0] MIN_T = HW'(HOLD_MIN_TICKS);
    localparam logic [HW-1:0] MAX_T = HW'(HOLD_MAX_TICKS);

    logic [HW-1:0] hcnt;
    logic          an_act;

    assign an_act = mac_an_en && phy_an_en && !link_dis;

    always_ff @(posedge clk) begin
        if (!rst_n || !tx_inhibit) begin
            hcnt <= '0;
        end else if (hcnt != MAX_T) begin
            hcnt <= hcnt + 1'b1;
        end
    end

    assert_inhibit_not_pass_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(tx_inhibit && link_pass));

    assert_hold_max_R5: assert property (@(posedge clk) disable iff (!rst_n)
        tx_inhibit |-> (hcnt < MAX_T));

    assert_hold_min_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!tx_inhibit && $past(tx_inhibit) && !$past(an_restart) && $past(an_act))
        |-> (hcnt >= MIN_T));

    assert_linkdis_pass_R3: assert property (@(posedge clk) disable iff (!rst_n)
        link_dis |=> link_pass);

    assert_restart_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (an_restart && an_act) |=> (!link_pass && !tx_inhibit && !neg_ack));

    assert_ack_rise_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (neg_ack && !$past(neg_ack)) |-> $past(neg_done));

    assert_mac_forced_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!link_dis && !mac_an_en && !link_pass)
        |=> (spd100 == $past(mac_spd100) && fdx == $past(mac_fdx)));

    assert_phy_forced_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!link_dis && mac_an_en && !phy_an_en && !link_pass)
        |=> (spd100 == $past(phy_spd100) && fdx == $past(phy_fdx)));

endmodule

bind link_mode_ctrl link_mode_ctrl_chk #(
    .HOLD_MIN_TICKS (HOLD_MIN_TICKS),
    .HOLD_MAX_TICKS (HOLD_MAX_TICKS)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .mac_an_en  (mac_an_en),
    .mac_spd100 (mac_spd100),
    .mac_fdx    (mac_fdx),
    .phy_an_en  (phy_an_en),
    .phy_spd100 (phy_spd100),
    .phy_fdx    (phy_fdx),
    .an_restart (an_restart),
    .link_dis   (link_dis),
    .neg_done   (neg_done),
    .spd100     (spd100),
    .fdx        (fdx),
    .link_pass  (link_pass),
    .tx_inhibit (tx_inhibit),
    .neg_ack    (neg_ack)
);

// File: tb/link_mode_ctrl_test.sv
`timescale 1ns/1ps
module link_mode_ctrl_test;

    localparam int HMIN = 120;
    localparam int HMAX = 150;
    localparam int HLEN = (HMIN + HMAX) / 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic mac_an_en = 0, mac_spd100 = 0, mac_fdx = 0;
    logic phy_an_en = 0, phy_spd100 = 0, phy_fdx = 0;
    logic an_restart = 0, link_dis = 0, link_good = 0;
    logic neg_done = 0, neg_spd100 = 0, neg_fdx = 0;
    logic spd100, fdx, link_pass, tx_inhibit, idle_txidle, neg_ack;

    int checks = 0;
    int bad = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    link_mode_ctrl #(.HOLD_MIN_TICKS(HMIN), .HOLD_MAX_TICKS(HMAX)) uut (
        .clk(clk), .rst_n(rst_n),
        .mac_an_en(mac_an_en), .mac_spd100(mac_spd100), .mac_fdx(mac_fdx),
        .phy_an_en(phy_an_en), .phy_spd100(phy_spd100), .phy_fdx(phy_fdx),
        .an_restart(an_restart), .link_dis(link_dis), .link_good(link_good),
        .neg_done(neg_done), .neg_spd100(neg_spd100), .neg_fdx(neg_fdx),
        .spd100(spd100), .fdx(fdx), .link_pass(link_pass),
        .tx_inhibit(tx_inhibit), .idle_txidle(idle_txidle), .neg_ack(neg_ack)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic t_reset();
        step();
        check("R9 spd100", spd100, 0);
        check("R9 link_pass", link_pass, 0);
        check("R9 tx_inhibit", tx_inhibit, 0);
        check("R9 neg_ack", neg_ack, 0);
        rst_n = 1'b1;
        step();
        check("R9 fdx after release", fdx, 0);
    endtask

    task automatic t_mac_forced();
        mac_an_en = 0; phy_an_en = 1; phy_spd100 = 0; phy_fdx = 0;
        mac_spd100 = 1; mac_fdx = 1; link_good = 0;
        step();
        check("R1 spd from MAC", spd100, 1);
        check("R1 fdx from MAC", fdx, 1);
        check("R7 idle at 100", idle_txidle, 1);
        check("R1 link down", link_pass, 0);
        link_good = 1;
        step();
        check("R1 link follows good", link_pass, 1);
        mac_spd100 = 0; mac_fdx = 0;
        step();
        check("R8 held in FRC_PASS spd", spd100, 1);
        check("R8 held in FRC_PASS fdx", fdx, 1);
        link_good = 0;
        step();
        check("R1 link drop", link_pass, 0);
        check("R8 load on transition", spd100, 0);
        check("R7 pulses at 10", idle_txidle, 0);
    endtask

    task automatic t_phy_forced();
        mac_an_en = 1; phy_an_en = 0; phy_spd100 = 1; phy_fdx = 0;
        mac_spd100 = 0; mac_fdx = 1; link_good = 0;
        step();
        check("R2 spd from PHY", spd100, 1);
        check("R2 fdx from PHY", fdx, 0);
    endtask

    task automatic t_link_dis();
        mac_an_en = 1; phy_an_en = 1; link_dis = 1; link_good = 0;
        phy_spd100 = 0; phy_fdx = 1; mac_spd100 = 1; mac_fdx = 0;
        step();
        check("R3 forced pass", link_pass, 1);
        check("R3 spd from PHY", spd100, 0);
        check("R3 fdx from PHY", fdx, 1);
        check("R7 pulses while disabled", idle_txidle, 0);
        an_restart = 1;
        step();
        an_restart = 0;
        check("R6 restart ignored forced pass", link_pass, 1);
        check("R6 restart ignored ack", neg_ack, 0);
        check("R6 restart ignored inhibit", tx_inhibit, 0);
    endtask

    task automatic negotiate_up(input logic s, input logic d);
        link_good = 1; neg_done = 1; neg_spd100 = s; neg_fdx = d;
        step();
        neg_done = 0;
    endtask

    task automatic t_negotiate();
        link_dis = 0; mac_an_en = 1; phy_an_en = 1; link_good = 0;
        step();
        check("R4 negotiating link down", link_pass, 0);
        check("R4 negotiating no inhibit", tx_inhibit, 0);
        neg_done = 1; neg_spd100 = 1; neg_fdx = 1;
        step();
        neg_done = 0;
        check("R4 strobe without link ignored", link_pass, 0);
        check("R4 strobe without link ack", neg_ack, 0);
        negotiate_up(1, 1);
        check("R4 pass", link_pass, 1);
        check("R4 ack", neg_ack, 1);
        check("R4 spd", spd100, 1);
        check("R4 fdx", fdx, 1);
        check("R7 TX idle at 100", idle_txidle, 1);
        neg_spd100 = 0; neg_fdx = 0;
        step();
        check("R4 result held after strobe", spd100, 1);
    endtask

    task automatic t_holdoff();
        int n;
        link_good = 0;
        step();
        check("R5 inhibit rises", tx_inhibit, 1);
        check("R5 link fail", link_pass, 0);
        check("R5 ack kept in hold", neg_ack, 1);
        n = 1;
        for (int i = 0; i < 1000; i++) begin
            step();
            if (!tx_inhibit) break;
            n++;
        end
        check("R5 hold length", n, HLEN);
        check("R5 hold >= min", int'(n >= HMIN), 1);
        check("R5 hold <= max", int'(n <= HMAX), 1);
        check("R5 back to negotiating ack", neg_ack, 0);
        check("R5 back to negotiating link", link_pass, 0);
    endtask

    task automatic t_restart();
        negotiate_up(0, 1);
        check("R6 pre pass", link_pass, 1);
        an_restart = 1;
        step();
        an_restart = 0;
        check("R6 restart drops link", link_pass, 0);
        check("R6 restart clears ack", neg_ack, 0);
        negotiate_up(0, 1);
        link_good = 0;
        repeat (10) step();
        check("R6 in hold", tx_inhibit, 1);
        an_restart = 1;
        step();
        an_restart = 0;
        check("R6 restart ends hold", tx_inhibit, 0);
        check("R6 restart from hold link", link_pass, 0);
        check("R6 restart from hold ack", neg_ack, 0);
    endtask

    initial begin
        t_reset();
        t_mac_forced();
        t_phy_forced();
        t_link_dis();
        t_negotiate();
        t_holdoff();
        t_restart();
        if (!finished) begin
            finished = 1;
            $display("test done: total=%0d bad=%0d", checks, bad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            bad++;
            $display("FAIL watchdog: actual=running expected=done");
            $display("test done: total=%0d bad=%0d", checks, bad);
            $finish;
        end
    end

endmodule